// File: doc/BRIEF.md
# Permission-Aware Cache Tag Directory

This block holds the tag and line-state store of a two-way, set-associative, write-back data cache, and classifies every load or store it receives. Each entry keeps a tag and four state bits: present, read-permitted, write-permitted and modified. Write permission means this cache holds the only copy of the line. For each request the block returns one of five outcomes after a fixed latency: hit, read miss, upgrade (the line is present and readable but not writable, so only permission is needed), exclusive miss (the whole line must be fetched with ownership), or uncached.

Whatever sits beside the block (miss queues, the bus agent) installs lines through a fill port. A fill either refreshes a line that is already present or allocates a way. Allocation takes an empty way first and otherwise the way named by a one-bit pseudo-LRU per set. Evicting a modified line raises a writeback pulse carrying that line's address. A snoop port lets a remote agent that is taking ownership remove a line. Cacheable memory is always allocate-on-read and allocate-on-write, and the fill port is where that allocation happens.

Top module: `lkp_tag_top`

## Requirements
- R1: A read from cacheable memory (resp_kind 0 = hit) hits only when a present line has a matching tag and read permission. A present line with matching tag but no read permission, or no matching line, gives resp_kind 1 (read miss). resp_way reports the matching way.
- R2: A write to cacheable memory hits (resp_kind 0) only when the matching present line has both read and write permission. Such a hit marks the line modified.
- R3: A write that matches a present, readable line without write permission gives resp_kind 2 (upgrade). The line stays present and readable.
- R4: A write with no matching line, or with a match that lacks read permission, gives resp_kind 3 (exclusive miss).
- R5: Any uncacheable request gives resp_kind 4. If a line matches, that line is invalidated.
- R6: A snoop removes the matching line and leaves other lines alone. A snoop and a fill in the same cycle act as snoop-then-fill, so the filled line stays present.
- R7: A fill with no matching line allocates the lowest-numbered empty way, else the pseudo-LRU way. A hit or a fill points the set's LRU bit at the other way.
- R8: Evicting a modified line pulses wb_valid in the cycle after the fill, with wb_addr = victim tag, set index, zero offset. Evicting a clean line raises no pulse.
- R9: A fill whose tag already matches a present line rewrites that line's permissions in place. It keeps the line's modified bit and evicts nothing.
- R10: resp_valid rises exactly HIT_LAT cycles after the cycle a request is presented. A request may be presented every cycle.
- R11: After reset every line is empty, and resp_valid and wb_valid are low.
- Address layout: offset [4:0], set index [8:5], tag [31:9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_cacheable | input | 1 | Target region is cacheable |
| req_addr | input | ADDR_W | Request byte address |
| fill_valid | input | 1 | Install or refresh a line |
| fill_addr | input | ADDR_W | Address of the line being filled |
| fill_readable | input | 1 | Grant read permission |
| fill_writable | input | 1 | Grant write permission (unique copy) |
| fill_dirty | input | 1 | Line is modified on arrival |
| snoop_valid | input | 1 | Remote ownership request, invalidate |
| snoop_addr | input | ADDR_W | Snooped address |
| resp_valid | output | 1 | Outcome valid |
| resp_kind | output | 3 | 0 hit, 1 read miss, 2 upgrade, 3 exclusive miss, 4 uncached |
| resp_way | output | 1 | Matching way, 0 when none |
| wb_valid | output | 1 | Modified victim must be written back |
| wb_addr | output | ADDR_W | Line address of that victim |

## Verification
The bench targets the distinction between a permission-only miss and a full refill. A design that tests only the tag would report a hit or an exclusive miss where an upgrade is due. Unreadable lines get probed, and a design that ignores the read bit would hit on them. An eviction sequence drives the one-bit LRU so that a clean victim and then a modified victim are chosen: a wrong victim shows up as the wrong surviving way, and a wrongly gated writeback shows up as a missing or spurious pulse or a bad address. In-place refresh, uncached invalidation, snoop selectivity, snoop/fill collision and back-to-back latency are each probed through later lookups.

// File: rtl/lkp_pkg.sv
package lkp_pkg;
  // The one-bit-per-set pseudo-LRU fixes associativity at two.
  localparam int NWAYS = 2;
  localparam int WAY_W = 1;

  typedef enum logic [2:0] {
    OUT_HIT      = 3'd0,
    OUT_RD_MISS  = 3'd1,
    OUT_UPGRADE  = 3'd2,
    OUT_EXCL     = 3'd3,
    OUT_UNCACHED = 3'd4
  } outcome_t;

  typedef struct packed {
    logic v;  // present
    logic r;  // read permitted
    logic w;  // write permitted, unique
    logic d;  // modified
  } line_flags_t;

  function automatic logic [WAY_W-1:0] first_way(input logic [NWAYS-1:0] vec);
    logic [WAY_W-1:0] res;
    res = '0;
    for (int i = NWAYS - 1; i >= 0; i--) begin
      if (vec[i]) res = WAY_W'(i);
    end
    return res;
  endfunction
endpackage

// File: rtl/lkp_probe.sv
module lkp_probe
  import lkp_pkg::*;
#(
  parameter int TAG_W = 23
) (
  input  logic [TAG_W-1:0] key,
  input  logic [TAG_W-1:0] st_tag [NWAYS],
  input  line_flags_t      st_flg [NWAYS],
  output logic [NWAYS-1:0] match
);
  for (genvar g = 0; g < NWAYS; g++) begin : g_way
    assign match[g] = st_flg[g].v && (st_tag[g] == key);
  end
endmodule

// File: rtl/lkp_classify.sv
module lkp_classify
  import lkp_pkg::*;
(
  input  logic             is_write,
  input  logic             cacheable,
  input  logic [NWAYS-1:0] match,
  input  line_flags_t      st_flg [NWAYS],
  output outcome_t         kind,
  output logic [WAY_W-1:0] way,
  output logic             inval
);
  logic        any;
  line_flags_t f;

  always_comb begin
    any   = |match;
    way   = first_way(match);
    f     = st_flg[way];
    inval = 1'b0;
    if (!cacheable) begin
      kind  = OUT_UNCACHED;
      inval = any;
    end else if (!is_write) begin
      kind = (any && f.r) ? OUT_HIT : OUT_RD_MISS;
    end else if (any && f.r && f.w) begin
      kind = OUT_HIT;
    end else if (any && f.r) begin
      kind = OUT_UPGRADE;
    end else begin
      kind = OUT_EXCL;
    end
  end
endmodule

// File: rtl/lkp_victim.sv
module lkp_victim
  import lkp_pkg::*;
(
  input  line_flags_t      st_flg [NWAYS],
  input  logic [WAY_W-1:0] lru_way,
  output logic [WAY_W-1:0] victim
);
  logic [NWAYS-1:0] empty;

  for (genvar g = 0; g < NWAYS; g++) begin : g_empty
    assign empty[g] = !st_flg[g].v;
  end

  assign victim = (|empty) ? first_way(empty) : lru_way;
endmodule

// File: rtl/lkp_resp_pipe.sv
module lkp_resp_pipe #(
  parameter int DEPTH = 2,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic         v_q [DEPTH];
  logic [W-1:0] d_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) v_q[i] <= 1'b0;
    end else begin
      v_q[0] <= in_valid;
      for (int i = 1; i < DEPTH; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    d_q[0] <= in_data;
    for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_data  = d_q[DEPTH-1];
endmodule

// File: rtl/lkp_tag_top.sv
module lkp_tag_top
  import lkp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int LINE_BYTES = 32,
  parameter int HIT_LAT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_cacheable,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_readable,
  input  logic              fill_writable,
  input  logic              fill_dirty,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              resp_valid,
  output logic [2:0]        resp_kind,
  output logic              resp_way,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int PAY_W = 3 + WAY_W;

  // State store: tags carry no reset, flags and LRU do.
  logic [TAG_W-1:0] tag_q [SETS][NWAYS];
  line_flags_t      flg_q [SETS][NWAYS];
  logic [SETS-1:0]  lru_q;

  // Address split for the three ports.
  logic [IDX_W-1:0] r_idx, f_idx, s_idx;
  logic [TAG_W-1:0] r_tag, f_tag, s_tag;
  assign r_idx = req_addr[OFF_W +: IDX_W];
  assign r_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign f_idx = fill_addr[OFF_W +: IDX_W];
  assign f_tag = fill_addr[ADDR_W-1 -: TAG_W];
  assign s_idx = snoop_addr[OFF_W +: IDX_W];
  assign s_tag = snoop_addr[ADDR_W-1 -: TAG_W];

  logic unused_offsets;
  assign unused_offsets = ^{req_addr[OFF_W-1:0], fill_addr[OFF_W-1:0], snoop_addr[OFF_W-1:0]};

  // Per-port views of the addressed set.
  logic [TAG_W-1:0] r_tags [NWAYS], f_tags [NWAYS], s_tags [NWAYS];
  line_flags_t      r_flgs [NWAYS], f_flgs [NWAYS], s_flgs [NWAYS];

  always_comb begin
    for (int w = 0; w < NWAYS; w++) begin
      r_tags[w] = tag_q[r_idx][w];
      r_flgs[w] = flg_q[r_idx][w];
      f_tags[w] = tag_q[f_idx][w];
      f_flgs[w] = flg_q[f_idx][w];
      s_tags[w] = tag_q[s_idx][w];
      s_flgs[w] = flg_q[s_idx][w];
    end
  end

  logic [NWAYS-1:0] r_match, f_match, s_match;

  lkp_probe #(.TAG_W(TAG_W)) u_probe_req (
    .key(r_tag), .st_tag(r_tags), .st_flg(r_flgs), .match(r_match));
  lkp_probe #(.TAG_W(TAG_W)) u_probe_fill (
    .key(f_tag), .st_tag(f_tags), .st_flg(f_flgs), .match(f_match));
  lkp_probe #(.TAG_W(TAG_W)) u_probe_snoop (
    .key(s_tag), .st_tag(s_tags), .st_flg(s_flgs), .match(s_match));

  // Request classification.
  outcome_t         cls_kind;
  logic [WAY_W-1:0] cls_way;
  logic             cls_inval;

  lkp_classify u_cls (
    .is_write (req_write),
    .cacheable(req_cacheable),
    .match    (r_match),
    .st_flg   (r_flgs),
    .kind     (cls_kind),
    .way      (cls_way),
    .inval    (cls_inval)
  );

  // Fill placement.
  logic [WAY_W-1:0] f_victim, f_way, s_way;
  logic             f_hit;
  line_flags_t      f_old, f_new;

  lkp_victim u_vict (
    .st_flg (f_flgs),
    .lru_way(lru_q[f_idx]),
    .victim (f_victim)
  );

  always_comb begin
    f_hit   = |f_match;
    f_way   = f_hit ? first_way(f_match) : f_victim;
    f_old   = f_flgs[f_way];
    s_way   = first_way(s_match);
    f_new   = line_flags_t'({1'b1, fill_readable, fill_writable,
                             fill_dirty | (f_hit & f_old.d)});
  end

  // State update order: request effects, then snoop, then fill.
  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q    <= '0;
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < NWAYS; w++)
          flg_q[s][w] <= '0;
    end else begin
      if (req_valid) begin
        if (cls_inval) flg_q[r_idx][cls_way] <= '0;
        if (cls_kind == OUT_HIT) begin
          lru_q[r_idx] <= ~cls_way;
          if (req_write) flg_q[r_idx][cls_way].d <= 1'b1;
        end
      end
      if (snoop_valid && (|s_match)) flg_q[s_idx][s_way] <= '0;
      if (fill_valid) begin
        flg_q[f_idx][f_way] <= f_new;
        lru_q[f_idx]        <= ~f_way;
      end
      wb_valid <= fill_valid && !f_hit && f_old.v && f_old.d;
      if (fill_valid)
        wb_addr <= {tag_q[f_idx][f_way], f_idx, {OFF_W{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid && !f_hit) tag_q[f_idx][f_way] <= f_tag;
  end

  // Fixed-latency outcome pipe.
  logic [PAY_W-1:0] pay_in, pay_out;
  assign pay_in = {cls_kind, cls_way};

  lkp_resp_pipe #(.DEPTH(HIT_LAT), .W(PAY_W)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_valid (req_valid),
    .in_data  (pay_in),
    .out_valid(resp_valid),
    .out_data (pay_out)
  );

  assign resp_kind = pay_out[PAY_W-1 -: 3];
  assign resp_way  = pay_out[0];
endmodule

// File: rtl/lkp_tag_chk.sv
module lkp_tag_chk #(
  parameter int HIT_LAT = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_write,
  input logic       req_cacheable,
  input logic       fill_valid,
  input logic       resp_valid,
  input logic [2:0] resp_kind,
  input logic       wb_valid
);
  logic h_v [HIT_LAT];
  logic h_w [HIT_LAT];
  logic h_c [HIT_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIT_LAT; i++) begin
        h_v[i] <= 1'b0; h_w[i] <= 1'b0; h_c[i] <= 1'b0;
      end
    end else begin
      h_v[0] <= req_valid; h_w[0] <= req_write; h_c[0] <= req_cacheable;
      for (int i = 1; i < HIT_LAT; i++) begin
        h_v[i] <= h_v[i-1]; h_w[i] <= h_w[i-1]; h_c[i] <= h_c[i-1];
      end
    end
  end

  logic ow, oc;
  assign ow = h_w[HIT_LAT-1];
  assign oc = h_c[HIT_LAT-1];

  AST_RESP_TIMING: assert property (@(posedge clk) disable iff (rst)
    resp_valid == h_v[HIT_LAT-1]);  // R10
  AST_UNCACHED_KIND: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ((resp_kind == 3'd4) == !oc));  // R5
  AST_READ_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && oc && !ow) |-> (resp_kind == 3'd0 || resp_kind == 3'd1));  // R1
  AST_WRITE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && oc && ow) |-> (resp_kind == 3'd0 || resp_kind == 3'd2 || resp_kind == 3'd3));  // R4
  AST_WB_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(fill_valid));  // R8
endmodule

bind lkp_tag_top lkp_tag_chk #(.HIT_LAT(HIT_LAT)) u_chk (.*);

// File: tb/sim_lkp_tag_top.sv
module sim_lkp_tag_top;
  localparam int ADDR_W  = 32;
  localparam int HIT_LAT = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 0, req_write = 0, req_cacheable = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              fill_valid = 0, fill_readable = 0, fill_writable = 0, fill_dirty = 0;
  logic [ADDR_W-1:0] fill_addr = '0;
  logic              snoop_valid = 0;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic              resp_valid, resp_way, wb_valid;
  logic [2:0]        resp_kind;
  logic [ADDR_W-1:0] wb_addr;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lkp_tag_top #(.ADDR_W(ADDR_W), .HIT_LAT(HIT_LAT)) u0 (.*);

  localparam logic [2:0] K_HIT = 0, K_RDM = 1, K_UPG = 2, K_EXC = 3, K_UNC = 4;

  function automatic logic [ADDR_W-1:0] mk(input int tg, input int ix);
    return {23'(tg), 4'(ix), 5'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input bit cch, input logic [ADDR_W-1:0] a,
                        input logic [2:0] kind, input bit chk_way, input bit way, input string req);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_cacheable = cch; req_addr = a + 4;
    @(posedge clk); #1;
    req_valid = 0;
    if (HIT_LAT > 1) chk(resp_valid == 0, "R10 early", resp_valid, 0);
    repeat (HIT_LAT - 1) @(posedge clk);
    #1;
    chk(resp_valid == 1, {req, " valid"}, resp_valid, 1);
    chk(resp_kind == kind, {req, " kind"}, resp_kind, kind);
    if (chk_way) chk(resp_way == way, {req, " way"}, resp_way, way);
  endtask

  task automatic do_fill(input logic [ADDR_W-1:0] a, input bit rd, input bit wr, input bit d,
                         input bit snp, input bit exp_wb, input logic [ADDR_W-1:0] exp_addr,
                         input string req);
    @(negedge clk);
    fill_valid = 1; fill_addr = a; fill_readable = rd; fill_writable = wr; fill_dirty = d;
    snoop_valid = snp; snoop_addr = a;
    @(posedge clk); #1;
    fill_valid = 0; snoop_valid = 0;
    chk(wb_valid == exp_wb, {req, " wb_valid"}, wb_valid, exp_wb);
    if (exp_wb) chk(wb_addr == exp_addr, {req, " wb_addr"}, wb_addr, exp_addr);
  endtask

  task automatic do_snoop(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    snoop_valid = 1; snoop_addr = a;
    @(posedge clk); #1;
    snoop_valid = 0;
  endtask

  // R10: two requests on consecutive cycles.
  task automatic back_to_back;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_cacheable = 1; req_addr = mk(3, 0);
    @(posedge clk); #1;
    for (int e = 1; e <= HIT_LAT + 1; e++) begin
      if (e > 1) begin @(posedge clk); #1; end
      if (e == 1) begin req_write = 1; req_addr = mk(6, 1); end
      if (e == 2) req_valid = 0;
      if (e == HIT_LAT) begin
        chk(resp_valid && resp_kind == K_HIT && resp_way == 1, "R10 first", resp_kind, K_HIT);
      end
      if (e == HIT_LAT + 1) begin
        chk(resp_valid && resp_kind == K_EXC, "R10 second", resp_kind, K_EXC);
      end
    end
    @(posedge clk); #1;
    chk(resp_valid == 0, "R10 drained", resp_valid, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    chk(resp_valid == 0, "R11 resp", resp_valid, 0);
    chk(wb_valid == 0, "R11 wb", wb_valid, 0);
    @(negedge clk); rst = 0;
    do_req(0, 1, mk(1, 0), K_RDM, 0, 0, "R11 empty");
  endtask

  task automatic t_perm;
    do_fill(mk(1, 0), 1, 0, 0, 0, 0, '0, "R7 fill A");
    do_req(0, 1, mk(1, 0), K_HIT, 1, 0, "R1 read hit");
    do_req(1, 1, mk(1, 0), K_UPG, 1, 0, "R3 upgrade");
    do_req(0, 1, mk(1, 0), K_HIT, 1, 0, "R3 kept");
    do_fill(mk(1, 0), 1, 1, 0, 0, 0, '0, "R9 in place");
    do_req(0, 1, mk(1, 0), K_HIT, 1, 0, "R9 same way");
    do_req(1, 1, mk(1, 0), K_HIT, 1, 0, "R2 write hit");
  endtask

  task automatic t_evict;
    do_fill(mk(2, 0), 1, 0, 0, 0, 0, '0, "R7 fill B");
    do_req(0, 1, mk(2, 0), K_HIT, 1, 1, "R7 B in empty way");
    do_req(0, 1, mk(1, 0), K_HIT, 1, 0, "R7 touch A");
    do_fill(mk(3, 0), 1, 0, 0, 0, 0, '0, "R8 clean victim");
    do_req(0, 1, mk(2, 0), K_RDM, 0, 0, "R7 B evicted");
    do_req(0, 1, mk(3, 0), K_HIT, 1, 1, "R7 C way");
    do_fill(mk(4, 0), 1, 0, 0, 0, 1, mk(1, 0), "R8 dirty victim");
    do_req(0, 1, mk(4, 0), K_HIT, 1, 0, "R7 D way");
    do_req(0, 1, mk(1, 0), K_RDM, 0, 0, "R8 A gone");
  endtask

  task automatic t_unreadable;
    do_fill(mk(5, 1), 0, 0, 0, 0, 0, '0, "R1 fill unreadable");
    do_req(0, 1, mk(5, 1), K_RDM, 1, 0, "R1 unreadable");
    do_req(1, 1, mk(5, 1), K_EXC, 0, 0, "R4 unreadable write");
    do_req(1, 1, mk(6, 1), K_EXC, 0, 0, "R4 no tag");
  endtask

  task automatic t_uncached;
    do_fill(mk(7, 2), 1, 1, 0, 0, 0, '0, "R5 fill F");
    do_req(0, 0, mk(7, 2), K_UNC, 0, 0, "R5 uncached hit");
    do_req(0, 1, mk(7, 2), K_RDM, 0, 0, "R5 invalidated");
    do_req(1, 0, mk(9, 9), K_UNC, 0, 0, "R5 uncached write");
  endtask

  task automatic t_snoop;
    do_fill(mk(8, 3), 1, 0, 0, 0, 0, '0, "R6 fill G");
    do_snoop(mk(8, 3));
    do_req(0, 1, mk(8, 3), K_RDM, 0, 0, "R6 snoop drop");
    do_fill(mk(9, 3), 1, 0, 0, 0, 0, '0, "R6 fill H");
    do_snoop(mk(10, 3));
    do_req(0, 1, mk(9, 3), K_HIT, 1, 0, "R6 other kept");
    do_fill(mk(11, 4), 1, 0, 0, 1, 0, '0, "R6 collide");
    do_req(0, 1, mk(11, 4), K_HIT, 1, 0, "R6 fill after snoop");
  endtask

  initial begin
    t_reset();
    t_perm();
    t_evict();
    t_unreadable();
    t_uncached();
    t_snoop();
    back_to_back();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule